// File: doc/BRIEF.md
# Folded Matrix-Vector Stream Controller

This block sequences the data path of a folded matrix-vector engine. An input vector arrives as a stream of slices, each holding `SIMD` activation elements. The engine has `PE` output lanes. Each arriving slice goes to the processing-element array in the cycle after it is accepted. The same slice is also stored in a local buffer. After the last slice of the vector, the controller stops accepting input and replays the stored slices once for each of the remaining row folds of the weight matrix. Row fold `r` covers output channels `r*PE` to `r*PE+PE-1`.

The controller issues one beat per cycle to the array. Each beat carries the slice together with the current row-fold and column-fold indices, which also address an external weight store. It also carries an accumulator-clear flag on the first column fold and a result flag on the last column fold. The array returns one word of `PE` results per row fold, a fixed number of cycles later. The controller queues these words in a small output FIFO that drives the output stream. A credit count of unread results lets computation run on briefly after the consumer stops taking data. Computation halts once all FIFO places are spoken for. A three-state control machine (idle, write, read) handles input stalls and backpressure.

Top module: `fold_mv_stream`

## Requirements
- R1: After the active-low asynchronous reset, `in_tready`, `pe_vld` and `m_tvalid` are all 0.
- R2: `in_tready` is 1 only while the controller is in its write state and fewer than `FIFO_DEPTH` results are outstanding. A result is outstanding from the issue of its last-column beat until its output word is taken.
- R3: For each input vector the controller issues `N_ROW*N_COL` beats in row-major order. Here `N_COL = KD*KD*IC/SIMD` and `N_ROW = OC/PE`. `pe_col` runs from 0 to `N_COL-1` within each row fold, and `pe_row` runs from 0 to `N_ROW-1`. `pe_clr` is 1 exactly on column 0, and `pe_last` is 1 exactly on column `N_COL-1`.
- R4: Row-fold-0 beats carry the accepted input slices in arrival order. Each beat appears on the PE outputs in the cycle after its handshake.
- R5: Beats of row folds 1 and higher carry the buffered slices of the same vector, again in arrival order. No input is accepted while these replay beats are issued.
- R6: Output words leave in row-fold order with none lost or duplicated. Lane `p` occupies bits `[p*AW +: AW]`. `m_tdata` holds steady while `m_tvalid` is 1 and `m_tready` is 0.
- R7: With `m_tready` held at 0, at most `FIFO_DEPTH` results are issued. After that, beat issue stops and the FIFO never overflows.
- R8: While `in_tvalid` is 0 in the middle of the row-0 pass, no beats are issued. The vector resumes correctly when input returns.
- R9: With input always valid and output always ready, beats are issued every cycle within a vector, including the replay passes.
- R10: When a vector ends and the next slice is already valid, the first beat of the next vector follows the last replay beat in the next cycle, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_tdata | input | SIMD*IW | Input slice, element k in bits [k*IW +: IW] |
| in_tvalid | input | 1 | Input slice valid |
| in_tready | output | 1 | Input slice accepted when also valid |
| pe_vld | output | 1 | Beat to the PE array is valid |
| pe_clr | output | 1 | Clear accumulators (first column fold) |
| pe_last | output | 1 | Last column fold; result follows |
| pe_row | output | RW | Row-fold index, weight-store address |
| pe_col | output | CW | Column-fold index, weight-store address |
| pe_slice | output | SIMD*IW | Activation slice for the PE array |
| res_vld | input | 1 | Result word from the PE array is valid |
| res_data | input | PE*AW | Result word, lane p in bits [p*AW +: AW] |
| m_tdata | output | PE*AW | Output stream data |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |

## Verification
The bench models the PE array with a fixed latency and a computed weight function. It predicts every beat and every output word from the slices that were actually accepted. Continuous input with an always-ready output exposes bubbles inside and between vectors. A vector with a long mid-row gap shows whether the controller issues beats without data. A stretch with the output stalled separates a credit-bounded run-on from both an immediate freeze and a FIFO overflow. Random valid and ready toggling then mixes all the state transitions, and the output words confirm that replayed data stays intact.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2
   } mvs_state_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mvs_fold_ctr.sv
module mvs_fold_ctr #(
   parameter int N = 4,
   localparam int W = mvs_pkg::idx_bits(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] idx,
   output logic         at_end
);
   assign at_end = (idx == W'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (step) idx <= at_end ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/mvs_inbuf.sv
module mvs_inbuf #(
   parameter int DEPTH = 9,
   parameter int WIDTH = 16,
   localparam int AW_ = mvs_pkg::idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW_-1:0]   waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW_-1:0]   raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mvs_ofifo.sv
module mvs_ofifo #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32,
   localparam int PW = mvs_pkg::idx_bits(DEPTH),
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             not_empty,
   output logic [CNTW-1:0]  cnt
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic             do_pop;

   assign not_empty = (cnt != '0);
   assign do_pop    = pop && not_empty;
   assign dout      = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push)   wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         cnt <= cnt + CNTW'(push) - CNTW'(do_pop);
      end
   end
endmodule

// File: rtl/fold_mv_stream.sv
module fold_mv_stream #(
   parameter int KD         = 3,
   parameter int IC         = 4,
   parameter int OC         = 8,
   parameter int SIMD       = 4,
   parameter int PE         = 2,
   parameter int IW         = 4,
   parameter int AW         = 16,
   parameter int PE_LAT     = 2,
   parameter int FIFO_DEPTH = 4,
   localparam int N_COL = KD * KD * IC / SIMD,
   localparam int N_ROW = OC / PE,
   localparam int CW    = mvs_pkg::idx_bits(N_COL),
   localparam int RW    = mvs_pkg::idx_bits(N_ROW),
   localparam int SW    = SIMD * IW,
   localparam int OWD   = PE * AW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [SW-1:0]  in_tdata,
   input  logic           in_tvalid,
   output logic           in_tready,
   output logic           pe_vld,
   output logic           pe_clr,
   output logic           pe_last,
   output logic [RW-1:0]  pe_row,
   output logic [CW-1:0]  pe_col,
   output logic [SW-1:0]  pe_slice,
   input  logic           res_vld,
   input  logic [OWD-1:0] res_data,
   output logic [OWD-1:0] m_tdata,
   output logic           m_tvalid,
   input  logic           m_tready
);
   import mvs_pkg::*;

   localparam int OSW = $clog2(FIFO_DEPTH + 1);

   if ((KD * KD * IC) % SIMD != 0) begin : g_chk_simd
      $error("KD*KD*IC must be a multiple of SIMD");
   end
   if (OC % PE != 0) begin : g_chk_pe
      $error("OC must be a multiple of PE");
   end
   if (FIFO_DEPTH < PE_LAT + 1) begin : g_chk_fifo
      $error("FIFO_DEPTH must cover PE_LAT plus one");
   end

   mvs_state_e     st, st_nx;
   logic [CW-1:0]  col;
   logic [RW-1:0]  row;
   logic           col_end, row_end;
   logic           credit_ok, issue, wr_beat;
   logic [OSW-1:0] outst;
   logic [OSW-1:0] fifo_cnt;
   logic [SW-1:0]  buf_rd, src_slice;

   assign credit_ok = (outst < OSW'(FIFO_DEPTH));
   assign in_tready = (st == ST_WRITE) && credit_ok;
   assign wr_beat   = in_tready && in_tvalid;
   assign issue     = wr_beat || ((st == ST_READ) && credit_ok);

   // control machine
   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (in_tvalid && credit_ok) st_nx = ST_WRITE;
         ST_WRITE: begin
            if (!wr_beat)                  st_nx = ST_IDLE;
            else if (col_end && N_ROW > 1) st_nx = ST_READ;
         end
         ST_READ:  if (issue && col_end && row_end)
                      st_nx = in_tvalid ? ST_WRITE : ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   // fold counters
   mvs_fold_ctr #(.N(N_COL)) u_col (
      .clk(clk), .rst_n(rst_n), .step(issue), .idx(col), .at_end(col_end)
   );
   mvs_fold_ctr #(.N(N_ROW)) u_row (
      .clk(clk), .rst_n(rst_n), .step(issue && col_end), .idx(row), .at_end(row_end)
   );

   // input buffer only when slices are replayed
   if (N_ROW > 1) begin : g_buf
      mvs_inbuf #(.DEPTH(N_COL), .WIDTH(SW)) u_buf (
         .clk(clk), .we(wr_beat), .waddr(col), .wdata(in_tdata),
         .raddr(col), .rdata(buf_rd)
      );
   end else begin : g_nobuf
      assign buf_rd = '0;
   end

   assign src_slice = (st == ST_WRITE) ? in_tdata : buf_rd;

   // registered beat toward the PE array
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_vld   <= 1'b0;
         pe_clr   <= 1'b0;
         pe_last  <= 1'b0;
         pe_row   <= '0;
         pe_col   <= '0;
         pe_slice <= '0;
      end else begin
         pe_vld <= issue;
         if (issue) begin
            pe_clr   <= (col == '0);
            pe_last  <= col_end;
            pe_row   <= row;
            pe_col   <= col;
            pe_slice <= src_slice;
         end
      end
   end

   // result credits: issued last beats not yet taken downstream
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outst <= '0;
      else        outst <= outst + OSW'(issue && col_end) - OSW'(m_tvalid && m_tready);
   end

   mvs_ofifo #(.DEPTH(FIFO_DEPTH), .WIDTH(OWD)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(res_vld), .din(res_data),
      .pop(m_tready), .dout(m_tdata), .not_empty(m_tvalid), .cnt(fifo_cnt)
   );
endmodule

// File: rtl/fold_mv_stream_chk.sv
module fold_mv_stream_chk #(
   parameter int FIFO_DEPTH = 4,
   parameter int CW   = 4,
   parameter int RW   = 2,
   parameter int OSW  = 3,
   parameter int OWD  = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_tvalid,
   input logic           in_tready,
   input logic           pe_vld,
   input logic [RW-1:0]  pe_row,
   input logic [CW-1:0]  pe_col,
   input logic           res_vld,
   input logic [OWD-1:0] m_tdata,
   input logic           m_tvalid,
   input logic           m_tready,
   input logic [OSW-1:0] outst,
   input logic [OSW-1:0] fifo_cnt
);
   logic [CW-1:0] last_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_col <= '0;
      else if (pe_vld) last_col <= pe_col;
   end

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_vld && pe_col != '0) |-> (last_col == CW'(pe_col - 1'b1))); // R3

   AST_ROW0_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_vld && pe_row == '0) |-> $past(in_tvalid && in_tready)); // R4

   AST_REPLAY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_vld && pe_row != '0) |-> $past(!(in_tvalid && in_tready))); // R5

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata))); // R6

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      outst <= OSW'(FIFO_DEPTH)); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (fifo_cnt < OSW'(FIFO_DEPTH))); // R7
endmodule

bind fold_mv_stream fold_mv_stream_chk #(
   .FIFO_DEPTH(FIFO_DEPTH), .CW(CW), .RW(RW), .OSW(OSW), .OWD(OWD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_tvalid(in_tvalid), .in_tready(in_tready),
   .pe_vld(pe_vld), .pe_row(pe_row), .pe_col(pe_col), .res_vld(res_vld),
   .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .outst(outst), .fifo_cnt(fifo_cnt)
);

// File: tb/fold_mv_stream_tb_top.sv
module fold_mv_stream_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int KD = 3, IC = 4, OC = 8, SIMD = 4, PE = 2, IW = 4, AW = 16;
   localparam int PE_LAT = 2, FIFO_DEPTH = 4;
   localparam int N_COL = KD * KD * IC / SIMD;
   localparam int N_ROW = OC / PE;
   localparam int CW = (N_COL > 1) ? $clog2(N_COL) : 1;
   localparam int RW = (N_ROW > 1) ? $clog2(N_ROW) : 1;
   localparam int SW = SIMD * IW;
   localparam int OWD = PE * AW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [SW-1:0]  in_tdata = '0;
   logic           in_tvalid = 1'b0;
   logic           in_tready;
   logic           pe_vld, pe_clr, pe_last;
   logic [RW-1:0]  pe_row;
   logic [CW-1:0]  pe_col;
   logic [SW-1:0]  pe_slice;
   logic           res_vld;
   logic [OWD-1:0] res_data;
   logic [OWD-1:0] m_tdata;
   logic           m_tvalid;
   logic           m_tready = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int beat_cnt = 0;
   int last_cnt = 0;
   int first_beat_cyc = -1;
   int last_beat_cyc = -1;

   int             eb_row[$];
   int             eb_col[$];
   logic [SW-1:0]  eb_sl[$];
   logic [OWD-1:0] exp_out[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   fold_mv_stream #(
      .KD(KD), .IC(IC), .OC(OC), .SIMD(SIMD), .PE(PE), .IW(IW), .AW(AW),
      .PE_LAT(PE_LAT), .FIFO_DEPTH(FIFO_DEPTH)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_tdata(in_tdata), .in_tvalid(in_tvalid),
      .in_tready(in_tready), .pe_vld(pe_vld), .pe_clr(pe_clr), .pe_last(pe_last),
      .pe_row(pe_row), .pe_col(pe_col), .pe_slice(pe_slice), .res_vld(res_vld),
      .res_data(res_data), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
   );

   function automatic int wgt(input int o, input int j);
      return (o * 7 + j * 3 + 1) % 5;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural PE array: accumulate on beats, deliver after PE_LAT cycles
   int             acc[PE];
   logic           pv[PE_LAT];
   logic [OWD-1:0] pd[PE_LAT];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PE_LAT; i++) pv[i] <= 1'b0;
      end else begin
         logic [OWD-1:0] w;
         w = '0;
         if (pe_vld) begin
            for (int p = 0; p < PE; p++) begin
               int s;
               s = 0;
               for (int k = 0; k < SIMD; k++)
                  s += int'(pe_slice[k*IW +: IW]) *
                       wgt(int'(pe_row) * PE + p, int'(pe_col) * SIMD + k);
               acc[p] = pe_clr ? s : acc[p] + s;
               w[p*AW +: AW] = AW'(acc[p]);
            end
         end
         pv[0] <= pe_vld && pe_last;
         pd[0] <= w;
         for (int i = 1; i < PE_LAT; i++) begin
            pv[i] <= pv[i-1];
            pd[i] <= pd[i-1];
         end
      end
   end
   assign res_vld  = pv[PE_LAT-1];
   assign res_data = pd[PE_LAT-1];

   always @(posedge clk) cyc++;

   // per-clock comparison of beats and output words against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && pe_vld) begin
         beat_cnt++;
         if (pe_last) last_cnt++;
         if (first_beat_cyc < 0) first_beat_cyc = cyc;
         last_beat_cyc = cyc;
         if (eb_row.size() == 0) begin
            check(0, "R3", "unexpected beat", 1, 0);
         end else begin
            int r, c;
            logic [SW-1:0] sl;
            r = eb_row.pop_front();
            c = eb_col.pop_front();
            sl = eb_sl.pop_front();
            check(int'(pe_row) == r, "R3", "beat row", pe_row, r);
            check(int'(pe_col) == c, "R3", "beat col", pe_col, c);
            check(pe_clr == (c == 0), "R3", "beat clear flag", pe_clr, c == 0);
            check(pe_last == (c == N_COL - 1), "R3", "beat last flag", pe_last, c == N_COL - 1);
            check(pe_slice == sl, (r == 0) ? "R4" : "R5", "beat slice", pe_slice, sl);
         end
      end
      if (rst_n && m_tvalid && m_tready) begin
         if (exp_out.size() == 0) check(0, "R6", "unexpected output word", 1, 0);
         else begin
            logic [OWD-1:0] e;
            e = exp_out.pop_front();
            check(m_tdata == e, "R6", "output word", m_tdata, e);
         end
      end
   end

   // drive n vectors; optional stall inside the first vector and random gaps
   task automatic send_vecs(input int n, input int stall_at, input int stall_len, input bit rnd);
      for (int v = 0; v < n; v++) begin
         logic [SW-1:0] sl[N_COL];
         for (int j = 0; j < N_COL; j++) begin
            sl[j] = SW'($urandom);
            if (v == 0 && j == stall_at) begin
               int b0;
               @(negedge clk);
               in_tvalid = 1'b0;
               repeat (2) @(negedge clk);
               b0 = beat_cnt;
               repeat (stall_len) @(negedge clk);
               check(beat_cnt == b0, "R8", "beats during input gap", beat_cnt - b0, 0);
            end
            forever begin
               @(negedge clk);
               if (rnd && ($urandom % 3 == 0)) begin
                  in_tvalid = 1'b0;
               end else begin
                  in_tvalid = 1'b1;
                  in_tdata  = sl[j];
                  #1;
                  if (in_tready) break;
               end
            end
            eb_row.push_back(0);
            eb_col.push_back(j);
            eb_sl.push_back(sl[j]);
         end
         for (int r = 1; r < N_ROW; r++)
            for (int j = 0; j < N_COL; j++) begin
               eb_row.push_back(r);
               eb_col.push_back(j);
               eb_sl.push_back(sl[j]);
            end
         for (int r = 0; r < N_ROW; r++) begin
            logic [OWD-1:0] w;
            for (int p = 0; p < PE; p++) begin
               int s;
               s = 0;
               for (int j = 0; j < N_COL * SIMD; j++)
                  s += int'(sl[j / SIMD][(j % SIMD)*IW +: IW]) * wgt(r * PE + p, j);
               w[p*AW +: AW] = AW'(s);
            end
            exp_out.push_back(w);
         end
      end
      @(negedge clk);
      in_tvalid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 500 && (exp_out.size() != 0 || eb_row.size() != 0); i++)
         @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(in_tready == 1'b0, "R1", "in_tready in reset", in_tready, 0);
      check(pe_vld == 1'b0, "R1", "pe_vld in reset", pe_vld, 0);
      check(m_tvalid == 1'b0, "R1", "m_tvalid in reset", m_tvalid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_tready == 1'b0, "R1", "in_tready idle after reset", in_tready, 0);

      // continuous input, always-ready output: back-to-back vectors
      m_tready = 1'b1;
      first_beat_cyc = -1;
      beat_cnt = 0;
      send_vecs(3, -1, 0, 1'b0);
      drain();
      check(beat_cnt == 3 * N_ROW * N_COL, "R3", "beats for three vectors", beat_cnt, 3 * N_ROW * N_COL);
      check(last_beat_cyc - first_beat_cyc + 1 == beat_cnt, "R9", "cycles spanned by beats",
            last_beat_cyc - first_beat_cyc + 1, beat_cnt);
      check(last_beat_cyc - first_beat_cyc + 1 == 3 * N_ROW * N_COL, "R10",
            "no bubble between vectors", last_beat_cyc - first_beat_cyc + 1, 3 * N_ROW * N_COL);

      // input gap in the middle of the row-0 pass
      send_vecs(1, 3, 10, 1'b0);
      drain();

      // output held off: run-on bounded by the FIFO
      m_tready = 1'b0;
      last_cnt = 0;
      fork
         send_vecs(2, -1, 0, 1'b0);
         begin
            repeat (150) @(negedge clk);
            check(last_cnt == FIFO_DEPTH, "R7", "results issued while stalled", last_cnt, FIFO_DEPTH);
            check(in_tready == 1'b0, "R2", "in_tready with credits exhausted", in_tready, 0);
            check(m_tvalid == 1'b1, "R6", "words held during stall", m_tvalid, 1);
            m_tready = 1'b1;
         end
      join
      drain();

      // random valid and random ready
      fork
         send_vecs(4, -1, 0, 1'b1);
         begin
            for (int i = 0; i < 400; i++) begin
               @(negedge clk);
               m_tready = ($urandom % 4 != 0);
            end
            m_tready = 1'b1;
         end
      join
      drain();

      check(exp_out.size() == 0, "R6", "output words left over", exp_out.size(), 0);
      check(eb_row.size() == 0, "R3", "beats left over", eb_row.size(), 0);
      check(m_tvalid == 1'b0, "R6", "FIFO empty at end", m_tvalid, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule